// File: doc/BRIEF.md
# Symbol Block Transmit Buffer and Sequencer

This block takes one transmit block of six-bit symbols from a host and frames it for a downstream symbol serializer. The host writes symbols into a shadow buffer over a plain address/data write port. A write to the last symbol address commits the block. The commit raises a one-cycle pulse toward an external parity engine, and the block then waits for the next block slot. At each block boundary a committed shadow block moves into the active buffer that feeds the serializer. If no commit has arrived by then, the active buffer keeps its old contents and the previous block goes out again.

Each block leaves as a stream of symbols on a valid/ready handshake. An optional preamble comes first, then the data symbols in address order, then the parity symbols, which the block reads one by one from the parity port by index. A transmitter-off input stops output at once. When it drops, a new block begins. A continuity bit is sampled at each block start and sent alongside every symbol of that block. The first block that starts after that bit rises is preceded by a run of alternating dotting bits and a fixed synchronisation word.

Top module: `sym_block_tx`

## Requirements
- R1: After reset, buf_free is 1, out_valid is 0 and par_start is 0.
- R2: An accepted write at address 0 to 46 stores wr_data as data symbol number wr_addr. A write to address 47 or above changes no symbol.
- R3: buf_free falls after the first accepted write of a load. While a committed block waits for transfer, writes are ignored and buf_free stays 0.
- R4: An accepted write to address 46 commits the block. par_start is 1 in the cycle after that write and 0 in the cycle after that.
- R5: out_valid is 0 in any cycle where tx_off is 1, including the cycle in which tx_off rises. When tx_off falls, a new block starts from its beginning.
- R6: A block is sent as [preamble], then the 47 data symbols in address order, then 16 parity symbols. Each parity symbol is the par_sym value present while par_idx shows its index, 0 to 15.
- R7: A committed block becomes the active block at the next block start, and buf_free returns to 1 at that point.
- R8: If no commit has happened since the last transfer, the next block repeats the previous active data unchanged.
- R9: out_ci equals cont_ind as sampled at the block start and stays constant for the whole block.
- R10: The first block that starts after cont_ind rises from 0 to 1, with cont_ind still 1 at that start, has a preamble. The preamble is 4 dotting symbols 6'h2A (bits alternate 1,0 starting with 1, most significant bit first), then the sync symbols 6'h34 and 6'h1B. Later blocks have no preamble until cont_ind rises again. cont_ind held at 1 out of reset counts as a rise.
- R11: The stream advances by one symbol only on a cycle where out_valid and out_ready are both 1. Otherwise out_sym and the position in the block are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host symbol write strobe |
| wr_addr | input | 6 | Symbol address of the write |
| wr_data | input | 6 | Symbol value of the write |
| buf_free | output | 1 | Shadow buffer is open for a new load |
| tx_off | input | 1 | 1 holds the transmitter off |
| cont_ind | input | 1 | Continuity bit: more blocks follow |
| par_start | output | 1 | One-cycle pulse on block commit |
| par_idx | output | 4 | Index of the parity symbol requested |
| par_sym | input | 6 | Parity symbol for par_idx |
| out_valid | output | 1 | A symbol is offered to the serializer |
| out_ready | input | 1 | Serializer accepts the offered symbol |
| out_sym | output | 6 | Offered symbol |
| out_ci | output | 1 | Continuity bit of the current block |

## Verification
The assertions assume that the parity engine returns a symbol for any par_idx with no handshake of its own, and that tx_off, cont_ind and out_ready change only between clock edges. The bench drives every input at the falling edge. It starts a new load only after the first symbol of a block has been seen, so the load never overlaps a transfer edge. out_ready is random, with roughly one refusal in four cycles. Data values come from a fixed-seed $urandom stream. The directed parts cover the idle preload, a stale resend, a rise of cont_ind at a block boundary, and an abort in the middle of a block.

// File: rtl/sym_block_tx_pkg.sv
package sym_block_tx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PRE  = 2'd1,
      ST_DATA = 2'd2,
      ST_PAR  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/sym_block_shadow.sv
module sym_block_shadow #(
   parameter int NUM_SYM = 47,
   parameter int SYM_W   = 6,
   parameter int ADDR_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [SYM_W-1:0]         wr_data,
   input  logic                     blk_start,
   output logic                     xfer,
   output logic [NUM_SYM*SYM_W-1:0] shadow_flat,
   output logic                     buf_free,
   output logic                     par_start
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_SYM - 1);

   generate
      if (NUM_SYM > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for NUM_SYM");
      end
   endgenerate

   logic pending, loading, wr_ok, commit;

   assign wr_ok  = wr_en && !pending && (wr_addr <= LAST_ADDR);
   assign commit = wr_ok && (wr_addr == LAST_ADDR);
   assign xfer   = blk_start && pending;
   assign buf_free = !pending && !loading;

   for (genvar i = 0; i < NUM_SYM; i++) begin : g_sym
      always_ff @(posedge clk) begin
         if (!rst_n)
            shadow_flat[i*SYM_W +: SYM_W] <= '0;
         else if (wr_ok && (wr_addr == ADDR_W'(i)))
            shadow_flat[i*SYM_W +: SYM_W] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending   <= 1'b0;
         loading   <= 1'b0;
         par_start <= 1'b0;
      end else begin
         par_start <= commit;
         if (xfer) pending <= 1'b0;
         if (commit) pending <= 1'b1;
         if (commit) loading <= 1'b0;
         else if (wr_ok) loading <= 1'b1;
      end
   end

   a_r3_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && pending) |=> $stable(shadow_flat));
   a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr > LAST_ADDR)) |=> $stable(shadow_flat));
   a_r4_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (par_start && !buf_free));
   a_r7_xfer_frees: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> !pending);
endmodule

// File: rtl/sym_block_active.sv
module sym_block_active #(
   parameter int NUM_SYM = 47,
   parameter int SYM_W   = 6,
   parameter int IDX_W   = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [NUM_SYM*SYM_W-1:0] shadow_flat,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [SYM_W-1:0]         rd_sym
);
   logic [NUM_SYM*SYM_W-1:0] act;

   always_ff @(posedge clk) begin
      if (!rst_n)   act <= '0;
      else if (load) act <= shadow_flat;
   end

   always_comb begin
      rd_sym = '0;
      for (int i = 0; i < NUM_SYM; i++)
         if (rd_idx == IDX_W'(i)) rd_sym = act[i*SYM_W +: SYM_W];
   end
endmodule

// File: rtl/sym_block_seq.sv
module sym_block_seq
   import sym_block_tx_pkg::*;
#(
   parameter int NUM_SYM   = 47,
   parameter int NUM_PAR   = 16,
   parameter int SYM_W     = 6,
   parameter int DOT_SYMS  = 4,
   parameter int SYNC_SYMS = 2,
   parameter logic [SYNC_SYMS*SYM_W-1:0] SYNC_WORD = 12'hD1B,
   parameter int IDX_W     = 6,
   parameter int PAR_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_off,
   input  logic             cont_ind,
   input  logic             out_ready,
   input  logic [SYM_W-1:0] data_sym,
   input  logic [SYM_W-1:0] par_sym,
   output logic [IDX_W-1:0] data_idx,
   output logic [PAR_W-1:0] par_idx,
   output logic             blk_start,
   output logic             out_valid,
   output logic [SYM_W-1:0] out_sym,
   output logic             out_ci
);
   localparam int PRE_SYMS = DOT_SYMS + SYNC_SYMS;
   localparam int MAX_A = (NUM_SYM > NUM_PAR) ? NUM_SYM : NUM_PAR;
   localparam int MAX_N = (MAX_A > PRE_SYMS) ? MAX_A : PRE_SYMS;
   localparam int CNT_W = $clog2(MAX_N);
   localparam logic [CNT_W-1:0] LAST_PRE  = CNT_W'(PRE_SYMS - 1);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(NUM_SYM - 1);
   localparam logic [CNT_W-1:0] LAST_PAR  = CNT_W'(NUM_PAR - 1);

   generate
      if (SYNC_SYMS < 1 || NUM_PAR < 2 || NUM_SYM < 2) begin : g_bad_cfg
         $error("sym_block_seq: unsupported parameter set");
      end
   endgenerate

   seq_state_e state;
   logic [CNT_W-1:0] cnt;
   logic ci_q, pre_arm, need_pre, fire, at_end;
   logic [SYM_W-1:0] pre_sym;

   generate
      if (DOT_SYMS == 0) begin : g_sync_only
         always_comb pre_sym = SYNC_WORD[(SYNC_SYMS-1-int'(cnt))*SYM_W +: SYM_W];
      end else begin : g_dot_sync
         always_comb begin
            pre_sym = '0;
            if (int'(cnt) < DOT_SYMS) begin
               for (int b = 0; b < SYM_W; b++)
                  pre_sym[b] = (((int'(cnt)*SYM_W + SYM_W - 1 - b) % 2) == 0);
            end else begin
               pre_sym = SYNC_WORD[(SYNC_SYMS-1-(int'(cnt)-DOT_SYMS))*SYM_W +: SYM_W];
            end
         end
      end
   endgenerate

   assign need_pre  = cont_ind && (pre_arm || !ci_q);
   assign out_valid = (state != ST_IDLE) && !tx_off;
   assign fire      = out_valid && out_ready;
   assign at_end    = fire && (state == ST_PAR) && (cnt == LAST_PAR);
   assign blk_start = !tx_off && ((state == ST_IDLE) || at_end);
   assign data_idx  = IDX_W'(cnt);
   assign par_idx   = PAR_W'(cnt);

   always_comb begin
      case (state)
         ST_PRE:  out_sym = pre_sym;
         ST_DATA: out_sym = data_sym;
         ST_PAR:  out_sym = par_sym;
         default: out_sym = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         ci_q    <= 1'b0;
         pre_arm <= 1'b0;
         out_ci  <= 1'b0;
      end else begin
         ci_q    <= cont_ind;
         pre_arm <= blk_start ? 1'b0 : need_pre;
         if (tx_off) begin
            state <= ST_IDLE;
            cnt   <= '0;
         end else if (blk_start) begin
            state  <= need_pre ? ST_PRE : ST_DATA;
            cnt    <= '0;
            out_ci <= cont_ind;
         end else if (fire) begin
            if (state == ST_PRE && cnt == LAST_PRE) begin
               state <= ST_DATA;
               cnt   <= '0;
            end else if (state == ST_DATA && cnt == LAST_DATA) begin
               state <= ST_PAR;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> ($stable(state) && $stable(cnt)));
   a_r5_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tx_off |=> (state == ST_IDLE));
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      at_end |=> ((state == ST_PRE || state == ST_DATA) && cnt == '0));
   a_r10_pre_ci: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRE) |-> out_ci);
   a_r9_ci_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_start && state != ST_IDLE) |=> $stable(out_ci));
endmodule

// File: rtl/sym_block_tx.sv
module sym_block_tx #(
   parameter int NUM_SYM   = 47,
   parameter int NUM_PAR   = 16,
   parameter int SYM_W     = 6,
   parameter int ADDR_W    = 6,
   parameter int DOT_SYMS  = 4,
   parameter int SYNC_SYMS = 2,
   parameter logic [SYNC_SYMS*SYM_W-1:0] SYNC_WORD = 12'hD1B,
   localparam int IDX_W    = $clog2(NUM_SYM),
   localparam int PAR_W    = $clog2(NUM_PAR)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [SYM_W-1:0]  wr_data,
   output logic              buf_free,
   input  logic              tx_off,
   input  logic              cont_ind,
   output logic              par_start,
   output logic [PAR_W-1:0]  par_idx,
   input  logic [SYM_W-1:0]  par_sym,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [SYM_W-1:0]  out_sym,
   output logic              out_ci
);
   logic blk_start, xfer;
   logic [NUM_SYM*SYM_W-1:0] shadow_flat;
   logic [IDX_W-1:0] data_idx;
   logic [SYM_W-1:0] data_sym;

   sym_block_shadow #(.NUM_SYM(NUM_SYM), .SYM_W(SYM_W), .ADDR_W(ADDR_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .blk_start(blk_start), .xfer(xfer), .shadow_flat(shadow_flat),
      .buf_free(buf_free), .par_start(par_start));

   sym_block_active #(.NUM_SYM(NUM_SYM), .SYM_W(SYM_W), .IDX_W(IDX_W)) u_active (
      .clk(clk), .rst_n(rst_n), .load(xfer), .shadow_flat(shadow_flat),
      .rd_idx(data_idx), .rd_sym(data_sym));

   sym_block_seq #(.NUM_SYM(NUM_SYM), .NUM_PAR(NUM_PAR), .SYM_W(SYM_W),
      .DOT_SYMS(DOT_SYMS), .SYNC_SYMS(SYNC_SYMS), .SYNC_WORD(SYNC_WORD),
      .IDX_W(IDX_W), .PAR_W(PAR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .tx_off(tx_off), .cont_ind(cont_ind),
      .out_ready(out_ready), .data_sym(data_sym), .par_sym(par_sym),
      .data_idx(data_idx), .par_idx(par_idx), .blk_start(blk_start),
      .out_valid(out_valid), .out_sym(out_sym), .out_ci(out_ci));
endmodule

// File: tb/sym_block_tx_bench.sv
module sym_block_tx_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, wr_en, buf_free, tx_off, cont_ind, par_start, out_valid, out_ready, out_ci;
   logic [5:0] wr_addr, wr_data, par_sym, out_sym;
   logic [3:0] par_idx;

   sym_block_tx u_sym_block_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .buf_free(buf_free), .tx_off(tx_off), .cont_ind(cont_ind), .par_start(par_start),
      .par_idx(par_idx), .par_sym(par_sym), .out_valid(out_valid), .out_ready(out_ready),
      .out_sym(out_sym), .out_ci(out_ci));

   function automatic int par_of(int k);
      return (k * 3 + 5) % 64;
   endfunction
   assign par_sym = 6'(par_of(int'(par_idx)));

   int n_chk = 0, n_bad = 0;
   int m_shadow[47], m_active[47];
   bit m_pending = 0;

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic host_wr(int a, int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'(a); wr_data = 6'(d);
      if (!m_pending && a < 47) begin
         m_shadow[a] = d;
         if (a == 46) m_pending = 1;
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Streams one block and compares it with the model; optionally loads a new block meanwhile
   task automatic stream(bit exp_pre, bit exp_ci, bit load_new, int abort_at, string tag);
      int ex[80];
      int n = 0, got = 0, waitc = 0, lcyc = -1;
      if (m_pending) begin
         m_active = m_shadow;
         m_pending = 0;
      end
      if (exp_pre) begin
         for (int i = 0; i < 4; i++) ex[n++] = 'h2A;
         ex[n++] = 'h34; ex[n++] = 'h1B;
      end
      for (int i = 0; i < 47; i++) ex[n++] = m_active[i];
      for (int i = 0; i < 16; i++) ex[n++] = par_of(i);
      while (got < n) begin
         @(negedge clk);
         if (lcyc >= 0) begin
            if (load_new && lcyc < 47) begin
               wr_en = 1'b1; wr_addr = 6'(lcyc); wr_data = 6'($urandom % 64);
               m_shadow[lcyc] = int'(wr_data);
               if (lcyc == 46) m_pending = 1;
            end else wr_en = 1'b0;
            lcyc++;
         end
         out_ready = ($urandom % 4) != 0;
         #1;
         if (load_new && lcyc == 2) chk("R3 buf_free after first write", int'(buf_free), 0);
         if (!out_valid) begin
            if (got != 0) begin chk("R5 valid dropped", 0, 1); return; end
            waitc++;
            if (waitc > 20) begin chk("R5 start timeout", 0, 1); return; end
         end else begin
            if (lcyc < 0) begin
               lcyc = 0;
               chk("R9 out_ci", int'(out_ci), int'(exp_ci));
               chk("R7 buf_free at start", int'(buf_free), 1);
               if (load_new) begin
                  wr_en = 1'b1; wr_addr = 6'd0; wr_data = 6'($urandom % 64);
                  m_shadow[0] = int'(wr_data);
                  lcyc = 1;
               end
            end
            if (got == abort_at) begin
               tx_off = 1'b1; wr_en = 1'b0;
               #1;
               chk("R5 valid low on tx_off", int'(out_valid), 0);
               return;
            end
            if (got >= n - 16) chk("R6 parity order", int'(out_sym), ex[got]);
            else if (exp_pre && got < 6) chk("R10 preamble", int'(out_sym), ex[got]);
            else chk(tag, int'(out_sym), ex[got]);
            if (out_ready) got++;
         end
      end
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk("watchdog", 0, 1);
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 47; i++) begin m_shadow[i] = 0; m_active[i] = 0; end
      rst_n = 1'b0; tx_off = 1'b1; cont_ind = 1'b0; wr_en = 1'b0;
      wr_addr = '0; wr_data = '0; out_ready = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 buf_free", int'(buf_free), 1);
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 par_start", int'(par_start), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R2: idle preload of block A, out-of-range write in the middle
      for (int i = 0; i < 46; i++) begin
         host_wr(i, int'($urandom % 64));
         if (i == 0) chk("R3 buf_free cleared", int'(buf_free), 0);
         if (i == 20) host_wr(50, 63);
      end
      chk("R5 idle while off", int'(out_valid), 0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'd46; wr_data = 6'd17;
      m_shadow[46] = 17; m_pending = 1;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk("R4 par_start pulse", int'(par_start), 1);
      @(negedge clk);
      #1;
      chk("R4 par_start ends", int'(par_start), 0);
      chk("R3 buf_free while pending", int'(buf_free), 0);
      host_wr(5, m_shadow[5] ^ 63);   // R3: ignored, model untouched while pending
      @(negedge clk);
      tx_off = 1'b0;
      stream(0, 0, 1, -1, "R2 block A data");
      stream(0, 0, 0, -1, "R7 block B data");
      stream(0, 0, 0, -1, "R8 stale resend");
      cont_ind = 1'b1;
      stream(1, 1, 0, -1, "R10 data after preamble");
      stream(0, 1, 1, -1, "R10 no second preamble");
      stream(0, 1, 0, 20, "R11 handshake");
      repeat (3) begin
         @(negedge clk);
         #1;
         chk("R5 off holds valid low", int'(out_valid), 0);
      end
      tx_off = 1'b0;
      stream(0, 1, 0, -1, "R5 restart from block start");
      cont_ind = 1'b0;
      stream(0, 0, 0, -1, "R9 ci low block");
      cont_ind = 1'b1;
      stream(1, 1, 0, -1, "R10 second rise");
      summary();
   end
endmodule